// File: doc/BRIEF.md
# Isolated Digital I/O Register Interface

This block is a bus-slave peripheral that gives a processor access to sixteen latched output lines and sixteen input lines through an eight-byte I/O window. The bus is a plain parallel one: a 3-bit address, a chip select, separate read and write strobes, 8-bit write data and 8-bit read data. The two output bytes are write-only. The two input bytes are read back through a two-stage synchronizer.

The block also raises a change-of-state interrupt. Any rising or falling edge on any synchronized input sets a pending latch while interrupts are enabled, and the request output follows that latch. Control uses access side effects only. A read at the control offset turns interrupts on. A write of any value to the same offset turns them off and drops the request. A write of any value to the low input offset clears the pending latch.

Every register update and side effect fires once per strobe, on the first clock cycle in which chip select and the strobe are both active.

Top module: `iso_dio_regif`

## Requirements
- R1: After reset both output bytes are 0x00, interrupts are disabled and the request output `irq` is low.
- R2: A write to offset 0 loads `dout[7:0]` and a write to offset 4 loads `dout[15:8]`; the other byte keeps its value.
- R3: A read of offset 1 returns the synchronized `din[7:0]` and offset 5 returns the synchronized `din[15:8]`; a change on `din` is not visible after one clock edge and is visible after three.
- R4: While `cs` and `rd` are both high, reads of offsets 0, 2, 3, 4, 6 and 7 return 0xFF; with no read in progress `rdata` is 0x00.
- R5: Writes to offsets 3, 5, 6 and 7 leave `dout` and `irq` unchanged.
- R6: After a read of offset 2, a rising or a falling edge on any input line drives `irq` high by the fourth clock edge after the change.
- R7: While interrupts are disabled, input changes leave `irq` low.
- R8: A write of any value to offset 1 drops `irq` on the next clock edge, with no effect on `dout`.
- R9: A write of any value to offset 2 disables interrupts and drops `irq`; later input changes leave `irq` low.
- R10: When a clear write to offset 1 and a detected input change fall in the same cycle, the change wins and `irq` stays high.
- R11: A strobe held for several cycles acts only once, with the address and data of its first active cycle.
- R12: Strobes with `cs` low have no effect on `dout`, the interrupt enable or `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, qualifies both strobes |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Byte offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `cs` and `rd` are high |
| din | input | 16 | Asynchronous input lines |
| dout | output | 16 | Latched output lines |
| irq | output | 1 | Interrupt request, high while an event is pending |

## Verification
The assertions assume that `addr` and `wdata` stay stable while a strobe is active, and that `rd` and `wr` are never high together. They also assume that `rst_n` is held long enough for the internal reset synchronizer to fill. The bench drives every bus signal on the falling clock edge and raises one strobe at a time. It changes `din` only on falling edges. The set-versus-clear collision is arranged by counting the synchronizer stages, so that the clear write falls exactly in the cycle where the change is detected.

// File: rtl/iso_dio_pkg.sv
package iso_dio_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_OUT_LO  = 3'd0,
    OFS_IN_LO   = 3'd1,
    OFS_IRQ_CTL = 3'd2,
    OFS_SPARE   = 3'd3,
    OFS_OUT_HI  = 3'd4,
    OFS_IN_HI   = 3'd5,
    OFS_RSV6    = 3'd6,
    OFS_RSV7    = 3'd7
  } ofs_e;

  // One-cycle side-effect pulses produced by the bus decoder
  typedef struct packed {
    logic [1:0] out_lane_wr;
    logic       irq_clear;
    logic       irq_off;
    logic       irq_on;
  } bus_evt_t;

  localparam logic [BYTE_W-1:0] RD_EMPTY = 8'hFF;
  localparam logic [BYTE_W-1:0] RD_IDLE  = 8'h00;

  function automatic logic [ADDR_W-1:0] out_lane_ofs(input int lane);
    return (lane == 0) ? OFS_OUT_LO : OFS_OUT_HI;
  endfunction

endpackage

// File: rtl/iso_dio_bus_decode.sv
module iso_dio_bus_decode
  import iso_dio_pkg::*;
#(
  parameter int N_LANES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_active,
  output bus_evt_t          evt
);

  logic rd_lvl, wr_lvl;
  logic rd_seen_q, wr_seen_q;
  logic rd_first, wr_first;

  assign rd_lvl    = cs & rd;
  assign wr_lvl    = cs & wr;
  assign rd_first  = rd_lvl & ~rd_seen_q;
  assign wr_first  = wr_lvl & ~wr_seen_q;
  assign rd_active = rd_lvl;

  // Strobe history: a pulse fires only on the first active cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_seen_q <= 1'b0;
      wr_seen_q <= 1'b0;
    end else begin
      rd_seen_q <= rd_lvl;
      wr_seen_q <= wr_lvl;
    end
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign evt.out_lane_wr[g] = wr_first && (addr == out_lane_ofs(g));
  end

  assign evt.irq_clear = wr_first && (addr == OFS_IN_LO);
  assign evt.irq_off   = wr_first && (addr == OFS_IRQ_CTL);
  assign evt.irq_on    = rd_first && (addr == OFS_IRQ_CTL);

endmodule

// File: rtl/iso_dio_in_sync.sv
module iso_dio_in_sync #(
  parameter int LINE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] din,
  output logic [LINE_W-1:0] sync_o,
  output logic              change_o
);

  logic [LINE_W-1:0] edge_vec;

  for (genvar g = 0; g < LINE_W; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sh_q, sh_d;
    logic                   prev_q;

    always_comb begin
      sh_d = {sh_q[SYNC_STAGES-2:0], din[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
      end else begin
        sh_q   <= sh_d;
        prev_q <= sh_q[SYNC_STAGES-1];
      end
    end

    assign sync_o[g]   = sh_q[SYNC_STAGES-1];
    assign edge_vec[g] = sh_q[SYNC_STAGES-1] ^ prev_q;
  end

  assign change_o = |edge_vec;

endmodule

// File: rtl/iso_dio_out_bank.sv
module iso_dio_out_bank
  import iso_dio_pkg::*;
#(
  parameter int N_LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LANES-1:0]        lane_wr,
  input  logic [BYTE_W-1:0]         wdata,
  output logic [N_LANES*BYTE_W-1:0] dout
);

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q, lane_d;
    logic              lane_en;

    assign lane_en = lane_wr[g];

    always_comb begin
      lane_d = lane_q;
      if (lane_en) lane_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign dout[g*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/iso_dio_irq_ctrl.sv
module iso_dio_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_on,
  input  logic irq_off,
  input  logic irq_clear,
  input  logic change,
  output logic irq_en,
  output logic irq
);

  logic en_q, en_d;
  logic pend_q, pend_d;
  logic set_evt;

  assign set_evt = en_q & change & ~irq_off;

  always_comb begin
    en_d = en_q;
    if (irq_off)     en_d = 1'b0;
    else if (irq_on) en_d = 1'b1;

    // Priority: disable forces low, then a new event, then a clear
    pend_d = pend_q;
    if (irq_off)        pend_d = 1'b0;
    else if (set_evt)   pend_d = 1'b1;
    else if (irq_clear) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign irq_en = en_q;
  assign irq    = pend_q;

endmodule

// File: rtl/iso_dio_regif.sv
module iso_dio_regif
  import iso_dio_pkg::*;
#(
  parameter int LINE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [LINE_W-1:0] din,
  output logic [LINE_W-1:0] dout,
  output logic              irq
);

  localparam int N_LANES = LINE_W / BYTE_W;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  bus_evt_t          evt;
  logic              rd_active;
  logic [LINE_W-1:0] in_sync;
  logic              in_change;
  logic              irq_en;

  iso_dio_bus_decode #(.N_LANES(N_LANES)) u_dec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs        (cs),
    .rd        (rd),
    .wr        (wr),
    .addr      (addr),
    .rd_active (rd_active),
    .evt       (evt)
  );

  iso_dio_in_sync #(.LINE_W(LINE_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .din      (din),
    .sync_o   (in_sync),
    .change_o (in_change)
  );

  iso_dio_out_bank #(.N_LANES(N_LANES)) u_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lane_wr (evt.out_lane_wr),
    .wdata   (wdata),
    .dout    (dout)
  );

  iso_dio_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .irq_on    (evt.irq_on),
    .irq_off   (evt.irq_off),
    .irq_clear (evt.irq_clear),
    .change    (in_change),
    .irq_en    (irq_en),
    .irq       (irq)
  );

  // Read mux: only the input bytes are readable
  always_comb begin
    rdata = RD_IDLE;
    if (rd_active) begin
      case (addr)
        OFS_IN_LO: rdata = in_sync[BYTE_W-1:0];
        OFS_IN_HI: rdata = in_sync[2*BYTE_W-1:BYTE_W];
        default:   rdata = RD_EMPTY;
      endcase
    end
  end

endmodule

// File: rtl/iso_dio_regif_chk.sv
module iso_dio_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs,
  input logic        rd,
  input logic        wr,
  input logic [2:0]  addr,
  input logic [7:0]  rdata,
  input logic [15:0] dout,
  input logic        irq,
  input logic        en,
  input logic        chg
);

  logic wr_hist_q;
  logic wr_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_hist_q <= 1'b0;
    else        wr_hist_q <= cs & wr;
  end
  assign wr_first = cs & wr & ~wr_hist_q;

  // R2
  a_r2_dout_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(cs && wr));

  // R4
  a_r4_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && (addr == 3'd3 || addr == 3'd6 || addr == 3'd7)) |-> rdata == 8'hFF);

  // R6
  a_r6_rise_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(en) && $past(chg)));

  // R7
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !irq) |=> !irq);

  // R9
  a_r9_off_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_first && addr == 3'd2) |=> (!irq && !en));

  // R10
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (en && chg && !(wr_first && addr == 3'd2)) |=> irq);

endmodule

bind iso_dio_regif iso_dio_regif_chk u_chk (
  .clk   (clk),
  .rst_n (rst_int_n),
  .cs    (cs),
  .rd    (rd),
  .wr    (wr),
  .addr  (addr),
  .rdata (rdata),
  .dout  (dout),
  .irq   (irq),
  .en    (irq_en),
  .chg   (in_change)
);

// File: tb/iso_dio_regif_test.sv
module iso_dio_regif_test;

  logic        clk;
  logic        rst_n;
  logic        cs, rd, wr;
  logic [2:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [15:0] din;
  logic [15:0] dout;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  iso_dio_regif uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .din(din), .dout(dout), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
    #5;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    #5 d = rdata;
    @(negedge clk);
    cs = 0; rd = 0;
    #5;
  endtask

  task automatic t_reset;
    check("R1 dout", dout, 16'h0000);
    check("R1 irq", irq, 1'b0);
    din = 16'h0055;
    idle(4);
    check("R7 irq after reset change", irq, 1'b0);
    din = 16'h0000;
    idle(4);
  endtask

  task automatic t_out_write;
    bus_wr(3'd0, 8'hA5);
    check("R2 low byte", dout, 16'h00A5);
    bus_wr(3'd4, 8'h3C);
    check("R2 high byte", dout, 16'h3CA5);
  endtask

  task automatic t_in_read;
    logic [7:0] d;
    @(negedge clk);
    din = 16'h1234;
    bus_rd(3'd1, d);
    check("R3 not yet visible", d, 8'h00);
    idle(2);
    bus_rd(3'd1, d);
    check("R3 low input byte", d, 8'h34);
    bus_rd(3'd5, d);
    check("R3 high input byte", d, 8'h12);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    bus_rd(3'd0, d); check("R4 read ofs0", d, 8'hFF);
    bus_rd(3'd3, d); check("R4 read ofs3", d, 8'hFF);
    bus_rd(3'd4, d); check("R4 read ofs4", d, 8'hFF);
    bus_rd(3'd6, d); check("R4 read ofs6", d, 8'hFF);
    bus_rd(3'd7, d); check("R4 read ofs7", d, 8'hFF);
    bus_rd(3'd2, d); check("R4 read ofs2", d, 8'hFF);
    bus_wr(3'd2, 8'h00);
    check("R4 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_ignored_writes;
    bus_wr(3'd3, 8'h11);
    bus_wr(3'd5, 8'h22);
    bus_wr(3'd6, 8'h33);
    bus_wr(3'd7, 8'h44);
    check("R5 dout unchanged", dout, 16'h3CA5);
    check("R5 irq unchanged", irq, 1'b0);
  endtask

  task automatic t_cs_gate;
    @(negedge clk);
    cs = 0; wr = 1; addr = 3'd0; wdata = 8'hFF;
    @(negedge clk);
    wr = 0; rd = 1; addr = 3'd2;
    @(negedge clk);
    rd = 0;
    #5 check("R12 dout without cs", dout, 16'h3CA5);
    din = din ^ 16'h0001;
    idle(5);
    check("R12 no enable without cs", irq, 1'b0);
  endtask

  task automatic t_disabled;
    din = din ^ 16'h8000;
    idle(5);
    check("R7 irq while disabled", irq, 1'b0);
  endtask

  task automatic t_irq_flow;
    logic [7:0] d;
    bus_rd(3'd2, d);
    din = din | 16'h0100;
    idle(4);
    check("R6 rising edge irq", irq, 1'b1);
    bus_wr(3'd1, 8'h5A);
    check("R8 clear drops irq", irq, 1'b0);
    check("R8 dout untouched", dout, 16'h3CA5);
    din = din & ~16'h0100;
    idle(4);
    check("R6 falling edge irq", irq, 1'b1);
    bus_wr(3'd2, 8'hC3);
    check("R9 disable drops irq", irq, 1'b0);
    din = din ^ 16'h0F0F;
    idle(5);
    check("R9 no irq after disable", irq, 1'b0);
  endtask

  task automatic t_set_wins;
    logic [7:0] d;
    bus_rd(3'd2, d);
    idle(1);
    din = din ^ 16'h0040;
    @(negedge clk);
    @(negedge clk);
    cs = 1; wr = 1; addr = 3'd1; wdata = 8'h00;
    @(negedge clk);
    cs = 0; wr = 0;
    #5 check("R10 set beats clear", irq, 1'b1);
    bus_wr(3'd1, 8'hFF);
    check("R8 later clear", irq, 1'b0);
    bus_wr(3'd2, 8'h00);
  endtask

  task automatic t_once;
    @(negedge clk);
    cs = 1; wr = 1; addr = 3'd0; wdata = 8'h81;
    @(negedge clk);
    wdata = 8'h7E;
    @(negedge clk);
    addr = 3'd4; wdata = 8'h99;
    @(negedge clk);
    cs = 0; wr = 0;
    #5 check("R11 held write acts once", dout, 16'h3C81);
  endtask

  initial begin
    cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0; din = 0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    t_reset();
    t_out_write();
    t_in_read();
    t_unmapped();
    t_ignored_writes();
    t_cs_gate();
    t_disabled();
    t_irq_flow();
    t_set_wins();
    t_once();
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule